// File: doc/BRIEF.md
# Prioritised Exception Entry Controller

This block sits beside the execute stage of a 32-bit processor core. Every cycle it looks at the pending exception requests, masks the two interrupt requests with the disable bits of the current status word, and picks the single most urgent one. For the chosen exception it registers a complete state-update bundle. The bundle holds the new status word, the copy of the old status word to be saved for the target mode, the return (link) address and the handler address to load into the program counter. A one-cycle take strobe marks the bundle as valid.

The status word uses a fixed layout that other parts of the core decode: bits [4:0] hold the mode, bit 5 selects the compact instruction state, bit 6 disables fast interrupts and bit 7 disables normal interrupts. Bits above 7 pass through unchanged on entry. Reset is an asynchronous, active-low level. It is also the highest-priority exception, and it is taken once in the first cycle after release.

When several requests are pending, they are served one per cycle. Each later decision uses the status word that the previous entry just produced, so an entry that sets a disable bit blocks the masked requests behind it at once.

Top module: `exc_entry_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `take` is 1 and `exc_code` is 0 (reset). The new status is 0x000000D3 (supervisor mode 10011, both disable bits set, compact-state bit clear), `save_en` is 0, `link_addr` is 0 and the handler address is the vector base.
- R2: Fixed priority, highest first, with `exc_code` values: reset 0, data abort 1, fast interrupt 2, normal interrupt 3, prefetch abort 4, undefined instruction 5, supervisor call 6.
- R3: With `hi_vec` low, `vector_addr` is 0x00 for reset, 0x04 for undefined, 0x08 for supervisor call, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt. 0x14 is never produced.
- R4: With `hi_vec` high, the same offsets are added to 0xFFFF0000.
- R5: Every entry clears status bit 5 and sets status bit 7. Bits above 7 are copied from the current status.
- R6: Status bit 6 is set on reset and fast-interrupt entry and is copied unchanged on every other entry.
- R7: Mode field [4:0] on entry: reset and supervisor call 10011, data and prefetch abort 10111, undefined 11011, normal interrupt 10010, fast interrupt 10001.
- R8: On every entry except reset, `save_en` is 1 and `saved_status` equals the status word current in that decision cycle.
- R9: `link_addr` is `inst_addr` + 8 for data abort, fast interrupt, normal interrupt and prefetch abort. It is `inst_addr` + 4 for undefined and supervisor call, where `inst_addr` is the address of the instruction in execute and instructions are 4 bytes.
- R10: A fast-interrupt request is not taken while status bit 6 is 1. A normal-interrupt request is not taken while status bit 7 is 1. With no other request pending, `take` stays 0.
- R11: At most one exception is taken per cycle. In the cycle right after a take, masking uses the new status just produced, so a normal interrupt pending behind any entry is blocked.
- R12: While `rst_n` is low, `take` is 0 and `new_status` shows the reset status 0x000000D3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; doubles as the reset exception |
| req_dabort | input | 1 | Data access fault pending |
| req_fast | input | 1 | Fast interrupt pending |
| req_norm | input | 1 | Normal interrupt pending |
| req_pabort | input | 1 | Instruction fetch fault reached execute |
| req_undef | input | 1 | Undefined instruction in execute |
| req_svcall | input | 1 | Supervisor call instruction in execute |
| status_in | input | STATUS_W | Current status word |
| inst_addr | input | ADDR_W | Address of the instruction in execute |
| hi_vec | input | 1 | Select the high vector base |
| take | output | 1 | One-cycle strobe: bundle below is valid |
| exc_code | output | 3 | Taken exception, R2 encoding |
| new_status | output | STATUS_W | Status word to load |
| saved_status | output | STATUS_W | Status copy for the target mode |
| save_en | output | 1 | Saved copy must be written |
| link_addr | output | ADDR_W | Return address for the target mode |
| vector_addr | output | ADDR_W | Handler address for the program counter |

## Verification
The hardest situation to reach is a run of back-to-back entries. There, each decision depends on the disable bits written by the entry one cycle earlier, before the surrounding core could have fed the new status back. The stimulus holds six requests at once from an unmasked user-mode status. It then drops only the request just served and checks that the entries chain in priority order, with the fast interrupt still admitted after the data abort while the normal interrupt is shut out. A second case releases reset with an undefined-instruction request already pending. This checks that reset wins the first cycle and that the held request follows with the reset status as its saved copy, under both vector bases.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int N_EXC = 7;

   typedef enum logic [2:0] {
      EXC_RESET  = 3'd0,
      EXC_DABORT = 3'd1,
      EXC_FAST   = 3'd2,
      EXC_NORM   = 3'd3,
      EXC_PABORT = 3'd4,
      EXC_UNDEF  = 3'd5,
      EXC_SVCALL = 3'd6
   } exc_code_e;

   // status word layout decoded elsewhere in the core
   localparam int BIT_CSTATE = 5;
   localparam int BIT_FDIS   = 6;
   localparam int BIT_NDIS   = 7;

   localparam logic [4:0] MODE_USER  = 5'b10000;
   localparam logic [4:0] MODE_FAST  = 5'b10001;
   localparam logic [4:0] MODE_NORM  = 5'b10010;
   localparam logic [4:0] MODE_SUPV  = 5'b10011;
   localparam logic [4:0] MODE_ABORT = 5'b10111;
   localparam logic [4:0] MODE_UNDEF = 5'b11011;
   localparam logic [4:0] MODE_SYS   = 5'b11111;

   function automatic logic [4:0] vec_offset(input exc_code_e c);
      case (c)
         EXC_RESET:  vec_offset = 5'h00;
         EXC_UNDEF:  vec_offset = 5'h04;
         EXC_SVCALL: vec_offset = 5'h08;
         EXC_PABORT: vec_offset = 5'h0C;
         EXC_DABORT: vec_offset = 5'h10;
         EXC_NORM:   vec_offset = 5'h18;
         EXC_FAST:   vec_offset = 5'h1C;
         default:    vec_offset = 5'h00;
      endcase
   endfunction

   function automatic logic [4:0] target_mode(input exc_code_e c);
      case (c)
         EXC_DABORT, EXC_PABORT: target_mode = MODE_ABORT;
         EXC_FAST:               target_mode = MODE_FAST;
         EXC_NORM:               target_mode = MODE_NORM;
         EXC_UNDEF:              target_mode = MODE_UNDEF;
         default:                target_mode = MODE_SUPV;
      endcase
   endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
   parameter int N = 7
) (
   input  logic [N-1:0]         req,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IDX_W = $clog2(N);

   logic [N:0]   blocked;
   logic [N-1:0] grant;

   assign blocked[0] = 1'b0;

   // bit 0 is the most urgent; each stage is blocked by anything above it
   for (genvar i = 0; i < N; i++) begin : g_stage
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
   end

   assign any = blocked[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
   end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
   import exc_entry_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int STATUS_W   = 32,
   parameter int INSN_BYTES = 4
) (
   input  exc_code_e             code,
   input  logic [STATUS_W-1:0]   cur_status,
   input  logic [ADDR_W-1:0]     inst_addr,
   output logic [STATUS_W-1:0]   nxt_status,
   output logic [ADDR_W-1:0]     link,
   output logic                  save
);
   localparam logic [ADDR_W-1:0] BIAS_NEXT  = ADDR_W'(INSN_BYTES);
   localparam logic [ADDR_W-1:0] BIAS_AFTER = ADDR_W'(INSN_BYTES + 4);
   localparam logic [ADDR_W-1:0] BIAS_FAULT = ADDR_W'(8);

   logic [ADDR_W-1:0] bias;

   always_comb begin
      nxt_status = cur_status;
      if (code == EXC_RESET) nxt_status = '0;
      nxt_status[4:0]        = target_mode(code);
      nxt_status[BIT_CSTATE] = 1'b0;
      nxt_status[BIT_NDIS]   = 1'b1;
      if (code == EXC_RESET || code == EXC_FAST) nxt_status[BIT_FDIS] = 1'b1;
   end

   // one adder; the per-exception difference lives in the bias select
   always_comb begin
      case (code)
         EXC_DABORT:            bias = BIAS_FAULT;
         EXC_FAST, EXC_NORM,
         EXC_PABORT:            bias = BIAS_AFTER;
         EXC_UNDEF, EXC_SVCALL: bias = BIAS_NEXT;
         default:               bias = '0;
      endcase
   end

   assign link = (code == EXC_RESET) ? '0 : inst_addr + bias;
   assign save = (code != EXC_RESET);
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
   import exc_entry_pkg::*;
#(
   parameter int                 ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]  HIGH_BASE = ADDR_W'(32'hFFFF_0000)
) (
   input  logic              hi_sel,
   input  exc_code_e         code,
   output logic [ADDR_W-1:0] vec
);
   logic [ADDR_W-1:0] base;

   if (HIGH_BASE[4:0] != 5'd0) begin : g_bad_base
      $error("exc_vec_gen: HIGH_BASE must leave the low 5 bits clear");
   end

   assign base = hi_sel ? HIGH_BASE : '0;
   assign vec  = base | ADDR_W'(vec_offset(code));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int STATUS_W   = 32,
   parameter int INSN_BYTES = 4,
   parameter logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(32'hFFFF_0000)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_dabort,
   input  logic                req_fast,
   input  logic                req_norm,
   input  logic                req_pabort,
   input  logic                req_undef,
   input  logic                req_svcall,
   input  logic [STATUS_W-1:0] status_in,
   input  logic [ADDR_W-1:0]   inst_addr,
   input  logic                hi_vec,
   output logic                take,
   output logic [2:0]          exc_code,
   output logic [STATUS_W-1:0] new_status,
   output logic [STATUS_W-1:0] saved_status,
   output logic                save_en,
   output logic [ADDR_W-1:0]   link_addr,
   output logic [ADDR_W-1:0]   vector_addr
);
   localparam int IDX_W = $clog2(N_EXC);
   localparam logic [STATUS_W-1:0] RST_STATUS =
      {{(STATUS_W-8){1'b0}}, 1'b1, 1'b1, 1'b0, MODE_SUPV};

   if (ADDR_W < 32) begin : g_addr_chk
      $error("exc_entry_ctrl: ADDR_W must be at least 32");
   end
   if (STATUS_W < 8) begin : g_stat_chk
      $error("exc_entry_ctrl: STATUS_W must be at least 8");
   end
   if (INSN_BYTES != 2 && INSN_BYTES != 4) begin : g_insn_chk
      $error("exc_entry_ctrl: INSN_BYTES must be 2 or 4");
   end

   logic                rst_pend_q;
   logic                take_q;
   exc_code_e           code_q;
   logic [STATUS_W-1:0] new_q;
   logic [STATUS_W-1:0] saved_q;
   logic                save_q;
   logic [ADDR_W-1:0]   link_q;

   logic [STATUS_W-1:0] eff_status;
   logic [N_EXC-1:0]    req_vec;
   logic                sel_any;
   logic [IDX_W-1:0]    sel_idx;
   exc_code_e           sel_code;
   logic [STATUS_W-1:0] calc_status;
   logic [ADDR_W-1:0]   calc_link;
   logic                calc_save;

   // the core loads new_q at the coming edge, so use it for this decision
   assign eff_status = take_q ? new_q : status_in;

   assign req_vec = {req_svcall,
                     req_undef,
                     req_pabort,
                     req_norm & ~eff_status[BIT_NDIS],
                     req_fast & ~eff_status[BIT_FDIS],
                     req_dabort,
                     rst_pend_q};

   exc_prio_arb #(.N(N_EXC)) u_arb (
      .req (req_vec),
      .any (sel_any),
      .idx (sel_idx)
   );

   assign sel_code = exc_code_e'(sel_idx);

   exc_state_calc #(
      .ADDR_W     (ADDR_W),
      .STATUS_W   (STATUS_W),
      .INSN_BYTES (INSN_BYTES)
   ) u_calc (
      .code       (sel_code),
      .cur_status (eff_status),
      .inst_addr  (inst_addr),
      .nxt_status (calc_status),
      .link       (calc_link),
      .save       (calc_save)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pend_q <= 1'b1;
         take_q     <= 1'b0;
         code_q     <= EXC_RESET;
         new_q      <= RST_STATUS;
         saved_q    <= '0;
         save_q     <= 1'b0;
         link_q     <= '0;
      end else begin
         rst_pend_q <= 1'b0;
         take_q     <= sel_any;
         if (sel_any) begin
            code_q  <= sel_code;
            new_q   <= calc_status;
            saved_q <= eff_status;
            save_q  <= calc_save;
            link_q  <= calc_link;
         end
      end
   end

   exc_vec_gen #(
      .ADDR_W    (ADDR_W),
      .HIGH_BASE (HIGH_BASE)
   ) u_vec (
      .hi_sel (hi_vec),
      .code   (code_q),
      .vec    (vector_addr)
   );

   assign take         = take_q;
   assign exc_code     = code_q;
   assign new_status   = new_q;
   assign saved_status = saved_q;
   assign save_en      = save_q;
   assign link_addr    = link_q;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
   parameter int ADDR_W     = 32,
   parameter int STATUS_W   = 32,
   parameter int INSN_BYTES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_dabort,
   input logic                hi_vec,
   input logic [ADDR_W-1:0]   inst_addr,
   input logic                take,
   input logic [2:0]          exc_code,
   input logic [STATUS_W-1:0] new_status,
   input logic [STATUS_W-1:0] saved_status,
   input logic                save_en,
   input logic [ADDR_W-1:0]   vector_addr,
   input logic [ADDR_W-1:0]   link_addr
);
   // R12
   rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> !take);

   // R2
   dabort_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_code > 3'd1) |-> !$past(req_dabort));

   // R5
   entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (!new_status[5] && new_status[7]));

   // R6
   fdis_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_code != 3'd0 && exc_code != 3'd2)
         |-> (new_status[6] == saved_status[6]));

   // R7
   fast_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_code == 3'd2) |-> (new_status[4:0] == 5'b10001));

   // R7
   abort_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (exc_code == 3'd1 || exc_code == 3'd4))
         |-> (new_status[4:0] == 5'b10111));

   // R8
   save_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (save_en == (exc_code != 3'd0)));

   // R10
   fast_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_code == 3'd2) |-> !saved_status[6]);

   // R10
   norm_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_code == 3'd3) |-> !saved_status[7]);

   // R9
   undef_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_code == 3'd5)
         |-> (link_addr == $past(inst_addr) + ADDR_W'(INSN_BYTES)));

   // R3
   low_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !hi_vec)
         |-> (vector_addr[ADDR_W-1:5] == '0 && vector_addr[4:0] != 5'h14));

   // R4
   high_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && hi_vec) |-> (vector_addr[31:16] == 16'hFFFF));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .STATUS_W   (STATUS_W),
   .INSN_BYTES (INSN_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_dabort   (req_dabort),
   .hi_vec       (hi_vec),
   .inst_addr    (inst_addr),
   .take         (take),
   .exc_code     (exc_code),
   .new_status   (new_status),
   .saved_status (saved_status),
   .save_en      (save_en),
   .vector_addr  (vector_addr),
   .link_addr    (link_addr)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_dabort, req_fast, req_norm, req_pabort, req_undef, req_svcall;
   logic [31:0] st;
   logic [31:0] inst_addr;
   logic        hi_vec;
   logic        take;
   logic [2:0]  exc_code;
   logic [31:0] new_status, saved_status, link_addr, vector_addr;
   logic        save_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   exc_entry_ctrl u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_dabort (req_dabort), .req_fast (req_fast), .req_norm (req_norm),
      .req_pabort (req_pabort), .req_undef (req_undef), .req_svcall (req_svcall),
      .status_in (st), .inst_addr (inst_addr), .hi_vec (hi_vec),
      .take (take), .exc_code (exc_code), .new_status (new_status),
      .saved_status (saved_status), .save_en (save_en),
      .link_addr (link_addr), .vector_addr (vector_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status(input int c, input logic [31:0] cur);
      logic [31:0] r;
      if (c == 0) return 32'h0000_00D3;
      r = cur;
      r[7] = 1'b1;
      r[5] = 1'b0;
      if (c == 2) r[6] = 1'b1;
      case (c)
         1, 4:    r[4:0] = 5'b10111;
         2:       r[4:0] = 5'b10001;
         3:       r[4:0] = 5'b10010;
         5:       r[4:0] = 5'b11011;
         default: r[4:0] = 5'b10011;
      endcase
      return r;
   endfunction

   function automatic logic [31:0] exp_vec(input int c, input logic hi);
      logic [31:0] off;
      case (c)
         1: off = 32'h10;  2: off = 32'h1C;  3: off = 32'h18;
         4: off = 32'h0C;  5: off = 32'h04;  6: off = 32'h08;
         default: off = 32'h00;
      endcase
      return (hi ? 32'hFFFF_0000 : 32'h0) + off;
   endfunction

   function automatic logic [31:0] exp_link(input int c, input logic [31:0] a);
      if (c == 0) return 32'h0;
      if (c == 5 || c == 6) return a + 32'd4;
      return a + 32'd8;
   endfunction

   task automatic drop_req(input int c);
      case (c)
         1: req_dabort = 1'b0;  2: req_fast = 1'b0;   3: req_norm = 1'b0;
         4: req_pabort = 1'b0;  5: req_undef = 1'b0;  6: req_svcall = 1'b0;
         default: ;
      endcase
   endtask

   // waits one clock edge, then checks the bundle and acts as the core
   task automatic expect_take(input int c, input string tag);
      logic [31:0] es;
      @(negedge clk);
      es = exp_status(c, st);
      chk({tag, " take"}, {31'd0, take}, 32'd1);
      chk({tag, " code R2"}, {29'd0, exc_code}, c);
      chk({tag, " vector R3/R4"}, vector_addr, exp_vec(c, hi_vec));
      chk({tag, " status R5/R6/R7"}, new_status, es);
      chk({tag, " save_en R8"}, {31'd0, save_en}, (c != 0) ? 32'd1 : 32'd0);
      if (c != 0) chk({tag, " saved R8"}, saved_status, st);
      chk({tag, " link R9"}, link_addr, exp_link(c, inst_addr));
      st = es;
      drop_req(c);
   endtask

   task automatic expect_idle(input string tag);
      @(negedge clk);
      chk({tag, " no take"}, {31'd0, take}, 32'd0);
   endtask

   task automatic t_reset(input logic hi, input logic pend_undef);
      @(negedge clk);
      rst_n = 1'b0;
      hi_vec = hi;
      req_undef = pend_undef;
      @(negedge clk);
      // R12
      chk("R12 take in reset", {31'd0, take}, 32'd0);
      chk("R12 status in reset", new_status, 32'h0000_00D3);
      rst_n = 1'b1;
      expect_take(0, "R1 reset entry");
      if (pend_undef) expect_take(5, "R2 undef after reset");
      expect_idle("R1 single reset take");
      hi_vec = 1'b0;
   endtask

   task automatic t_single(input int c, input logic hi);
      @(negedge clk);
      st = 32'hA000_0010;
      hi_vec = hi;
      inst_addr = 32'h0000_1000 + 32'(c) * 32'h40;
      case (c)
         1: req_dabort = 1'b1;  2: req_fast = 1'b1;   3: req_norm = 1'b1;
         4: req_pabort = 1'b1;  5: req_undef = 1'b1;  default: req_svcall = 1'b1;
      endcase
      expect_take(c, "R7 single entry");
      expect_idle("R11 single entry one take");
      hi_vec = 1'b0;
   endtask

   task automatic t_masked();
      @(negedge clk);
      st = 32'h0000_0050;
      req_fast = 1'b1;
      expect_idle("R10 fast masked a");
      expect_idle("R10 fast masked b");
      @(negedge clk);
      req_fast = 1'b0;
      st = 32'h0000_0090;
      req_norm = 1'b1;
      expect_idle("R10 norm masked a");
      expect_idle("R10 norm masked b");
      st = 32'h0000_0010;
      expect_take(3, "R10 norm unmasked");
      expect_idle("R10 after norm");
   endtask

   task automatic t_chain();
      @(negedge clk);
      st = 32'h0000_0010;
      inst_addr = 32'h0000_2000;
      req_dabort = 1'b1; req_fast = 1'b1; req_norm = 1'b1;
      req_pabort = 1'b1; req_undef = 1'b1; req_svcall = 1'b1;
      expect_take(1, "R2 chain dabort");
      expect_take(2, "R11 chain fast");
      expect_take(4, "R11 chain pabort");
      expect_take(5, "R2 chain undef");
      expect_take(6, "R2 chain svcall");
      expect_idle("R11 norm blocked a");
      expect_idle("R11 norm blocked b");
      st = 32'h0000_0010;
      expect_take(3, "R11 norm after unmask");
   endtask

   task automatic t_fast_norm();
      @(negedge clk);
      st = 32'h0000_001F;
      req_fast = 1'b1; req_norm = 1'b1;
      expect_take(2, "R11 fast before norm");
      expect_idle("R11 norm blocked by fast entry");
      @(negedge clk);
      req_norm = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; hi_vec = 1'b0; st = 32'h0; inst_addr = 32'h0;
      req_dabort = 1'b0; req_fast = 1'b0; req_norm = 1'b0;
      req_pabort = 1'b0; req_undef = 1'b0; req_svcall = 1'b0;
      repeat (2) @(negedge clk);
      t_reset(1'b0, 1'b0);
      for (int c = 1; c <= 6; c++) t_single(c, 1'b0);
      t_single(5, 1'b1);
      t_single(2, 1'b1);
      t_masked();
      t_chain();
      t_fast_norm();
      t_reset(1'b1, 1'b1);
      t_reset(1'b0, 1'b1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule